// File: doc/BRIEF.md
# Per-Output Interrupt Mask and Priority Encoder

This block sits between three sources of pending interrupts and a set of output interrupt lines. The three sources are programmable timers, external hardware lines and software-triggered mailboxes. Each output line has a mask for each source type. The output is raised whenever any pending source that it has unmasked is present. Software reaches the masks through a word-addressed register window of 4 KB. Each mask can be written in three ways: a plain load, a bitwise OR that enables sources, and an AND with the complement that disables them. The window also gives read access to the masks, to the masked "active" vectors and to a packed priority word. That word names the lowest-index active source of each type.

The blocks that produce the pending vectors are outside this unit, and so is the bus bridge that drives its register strobe. Reads are combinational from the current masks and pending inputs. A write takes effect at the next rising clock edge.

Top module: `irq_route_hub`

## Requirements
- R1: The register offset is decoded as function = addr[11:7] and output index = addr[6:2]. Bits 1:0 are not decoded. A write whose index is not below N_OUT changes no mask.
- R2: A write with function 4 (timer), 8 (hardware) or 12 (software) loads the selected output's mask of that type. A read with the same function returns that mask. Mask bits at or above the source count of the type always read 0.
- R3: A write with function 5, 9 or 13 ORs the written bits into the selected output's timer, hardware or software mask.
- R4: A write with function 6, 10 or 14 clears, in the selected output's timer, hardware or software mask, every bit that is 1 in the written data.
- R5: A read with function 6, 10 or 14 returns the pending vector of the timer, hardware or software type ANDed with the selected output's mask of that type.
- R6: A read with function 15 returns the priority word. Bit 0 is set if any timer source is active, bit 1 if any hardware source is active and bit 2 if any software source is active. Bits 12:8 give the lowest active timer index, bits 20:16 the lowest active hardware index and bits 28:24 the lowest active software index. All other bits are 0.
- R7: An index field of the priority word reads 0 when its any-active bit is clear.
- R8: A read with function 16 returns the configuration word: the timer count in bits 5:0, the hardware-line count in 13:8, the software count in 21:16 and the output count in 29:24. All other bits are 0.
- R9: irq_out[k] is 1 exactly when at least one of the three active vectors of output k is non-zero. It follows pending changes in the same cycle and mask writes from the next rising edge.
- R10: Reset clears every mask, so all outputs are 0 and every mask reads 0 whatever the pending inputs are.
- R11: A read with any other function (0, 5, 9, 13, 7, 11, 17 and above) returns 0. A read of a per-output function whose index is not below N_OUT also returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register window |
| reg_addr | input | 12 | Byte offset in the register window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| pti_pend | input | N_PTI | Pending timer interrupts |
| hwi_pend | input | N_HWI | Pending hardware lines |
| wti_pend | input | N_WTI | Pending software-triggered interrupts |
| irq_out | output | N_OUT | Output interrupt lines |

## Verification
Two situations are hard to reach from the ports. In the first, a priority word has all three types active at once with non-trivial lowest indices. In the second, a mask has been built up by a mix of OR and AND-NOT writes and never loaded directly. The stimulus makes the pending vectors sparse by ANDing several random words, so that the lowest set bit moves around. It also chooses the function code from a list weighted toward the enable and disable forms, so that masks build up over many writes. Directed steps cover the index past the last output, bits above a type's source count, and a mask that has been fully cleared.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

  typedef enum logic [1:0] {
    SRC_TMR = 2'd0,
    SRC_HW  = 2'd1,
    SRC_SW  = 2'd2
  } src_kind_e;

  localparam int unsigned NUM_SRC  = 3;
  localparam logic [4:0]  FN_PRIO  = 5'd15;
  localparam logic [4:0]  FN_CFG   = 5'd16;

  // first function code of the four-code group of a source type
  function automatic logic [4:0] fn_base(input int unsigned s);
    return 5'(4 + 4 * s);
  endfunction

endpackage

// File: rtl/irq_hub_decode.sv
module irq_hub_decode
  import irq_hub_pkg::*;
#(
  parameter int unsigned N_OUT = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr,
  input  logic [11:0]               addr,
  output logic [4:0]                fn,
  output logic [4:0]                idx,
  output logic                      idx_ok,
  output logic [NUM_SRC*N_OUT-1:0]  op_load,
  output logic [NUM_SRC*N_OUT-1:0]  op_or,
  output logic [NUM_SRC*N_OUT-1:0]  op_clr
);

  assign fn     = addr[11:7];
  assign idx    = addr[6:2];
  assign idx_ok = ({27'd0, idx} < N_OUT);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    for (genvar o = 0; o < N_OUT; o++) begin : g_out
      logic hit;
      assign hit = wr && idx_ok && (idx == 5'(o));
      assign op_load[s*N_OUT+o] = hit && (fn == fn_base(s));
      assign op_or  [s*N_OUT+o] = hit && (fn == fn_base(s) + 5'd1);
      assign op_clr [s*N_OUT+o] = hit && (fn == fn_base(s) + 5'd2);
    end
  end

  // at most one mask strobe per write, and only for an in-range index
  assert_one_strobe_R1 : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op_load, op_or, op_clr}));
  assert_range_R1 : assert property (@(posedge clk) disable iff (!rst_n)
    !idx_ok |-> ({op_load, op_or, op_clr} == '0));

endmodule

// File: rtl/irq_hub_mask_bank.sv
module irq_hub_mask_bank #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_load,
  input  logic         op_or,
  input  logic         op_clr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pend,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] active
);

  logic [W-1:0] mask_d;
  logic         mask_en;

  assign mask_en = op_load | op_or | op_clr;

  always_comb begin
    mask_d = mask_q;
    if (op_load)     mask_d = wdata;
    else if (op_or)  mask_d = mask_q | wdata;
    else if (op_clr) mask_d = mask_q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end

  assign active = pend & mask_q;

  assert_load_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    op_load |=> mask_q == $past(wdata));
  assert_or_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    op_or |=> ((mask_q & $past(wdata)) == $past(wdata))
              && ((mask_q & ~$past(wdata)) == ($past(mask_q) & ~$past(wdata))));
  assert_clr_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    op_clr |=> ((mask_q & $past(wdata)) == '0)
               && ((mask_q & ~$past(wdata)) == ($past(mask_q) & ~$past(wdata))));
  assert_hold_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    !(op_load | op_or | op_clr) |=> $stable(mask_q));

endmodule

// File: rtl/irq_hub_prio_enc.sv
module irq_hub_prio_enc #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] vec,
  output logic         any,
  output logic [4:0]   idx
);

  always_comb begin
    idx = 5'd0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = 5'(i);
    end
  end

  assign any = |vec;

  assert_prio_hit_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    any |-> ((32'(vec) >> idx) & 32'd1) == 32'd1);
  assert_prio_lowest_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (32'(vec) & ((32'd1 << idx) - 32'd1)) == 32'd0);
  assert_prio_idle_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    (vec == '0) |-> (idx == 5'd0) && !any);

endmodule

// File: rtl/irq_route_hub.sv
module irq_route_hub
  import irq_hub_pkg::*;
#(
  parameter int unsigned N_PTI = 8,
  parameter int unsigned N_HWI = 16,
  parameter int unsigned N_WTI = 4,
  parameter int unsigned N_OUT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [11:0]      reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [N_PTI-1:0] pti_pend,
  input  logic [N_HWI-1:0] hwi_pend,
  input  logic [N_WTI-1:0] wti_pend,
  output logic [N_OUT-1:0] irq_out
);

  localparam logic [31:0] CFG_WORD = {2'b00, 6'(N_OUT), 2'b00, 6'(N_WTI),
                                      2'b00, 6'(N_HWI), 2'b00, 6'(N_PTI)};

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [4:0]               fn, idx;
  logic                     idx_ok;
  logic [NUM_SRC*N_OUT-1:0] op_load, op_or, op_clr;

  irq_hub_decode #(.N_OUT(N_OUT)) u_dec (
    .clk(clk), .rst_n(rst_int_n), .wr(reg_wr), .addr(reg_addr),
    .fn(fn), .idx(idx), .idx_ok(idx_ok),
    .op_load(op_load), .op_or(op_or), .op_clr(op_clr)
  );

  logic [31:0] msk_w [NUM_SRC][N_OUT];
  logic [31:0] act_w [NUM_SRC][N_OUT];
  logic        any_w [NUM_SRC][N_OUT];
  logic [4:0]  top_w [NUM_SRC][N_OUT];

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic [N_PTI-1:0] t_msk, t_act;
    logic [N_HWI-1:0] h_msk, h_act;
    logic [N_WTI-1:0] w_msk, w_act;

    irq_hub_mask_bank #(.W(N_PTI)) u_tmr (
      .clk(clk), .rst_n(rst_int_n),
      .op_load(op_load[SRC_TMR*N_OUT+o]), .op_or(op_or[SRC_TMR*N_OUT+o]),
      .op_clr(op_clr[SRC_TMR*N_OUT+o]), .wdata(reg_wdata[N_PTI-1:0]),
      .pend(pti_pend), .mask_q(t_msk), .active(t_act)
    );
    irq_hub_mask_bank #(.W(N_HWI)) u_hw (
      .clk(clk), .rst_n(rst_int_n),
      .op_load(op_load[SRC_HW*N_OUT+o]), .op_or(op_or[SRC_HW*N_OUT+o]),
      .op_clr(op_clr[SRC_HW*N_OUT+o]), .wdata(reg_wdata[N_HWI-1:0]),
      .pend(hwi_pend), .mask_q(h_msk), .active(h_act)
    );
    irq_hub_mask_bank #(.W(N_WTI)) u_sw (
      .clk(clk), .rst_n(rst_int_n),
      .op_load(op_load[SRC_SW*N_OUT+o]), .op_or(op_or[SRC_SW*N_OUT+o]),
      .op_clr(op_clr[SRC_SW*N_OUT+o]), .wdata(reg_wdata[N_WTI-1:0]),
      .pend(wti_pend), .mask_q(w_msk), .active(w_act)
    );

    assign msk_w[SRC_TMR][o] = 32'(t_msk);
    assign msk_w[SRC_HW][o]  = 32'(h_msk);
    assign msk_w[SRC_SW][o]  = 32'(w_msk);
    assign act_w[SRC_TMR][o] = 32'(t_act);
    assign act_w[SRC_HW][o]  = 32'(h_act);
    assign act_w[SRC_SW][o]  = 32'(w_act);

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_enc
      irq_hub_prio_enc #(.W(32)) u_enc (
        .clk(clk), .rst_n(rst_int_n), .vec(act_w[s][o]),
        .any(any_w[s][o]), .idx(top_w[s][o])
      );
    end

    assign irq_out[o] = any_w[SRC_TMR][o] | any_w[SRC_HW][o] | any_w[SRC_SW][o];
  end

  // read mux
  always_comb begin
    reg_rdata = 32'd0;
    if (fn == FN_CFG) begin
      reg_rdata = CFG_WORD;
    end else if (idx_ok) begin
      for (int o = 0; o < N_OUT; o++) begin
        if (idx == 5'(o)) begin
          if (fn == FN_PRIO) begin
            reg_rdata = {3'b000, top_w[SRC_SW][o], 3'b000, top_w[SRC_HW][o],
                         3'b000, top_w[SRC_TMR][o], 5'b00000,
                         any_w[SRC_SW][o], any_w[SRC_HW][o], any_w[SRC_TMR][o]};
          end
          for (int s = 0; s < NUM_SRC; s++) begin
            if (fn == fn_base(s))         reg_rdata = msk_w[s][o];
            if (fn == fn_base(s) + 5'd2)  reg_rdata = act_w[s][o];
          end
        end
      end
    end
  end

endmodule

// File: tb/irq_route_hub_bench.sv
module irq_route_hub_bench;

  localparam int NP = 8, NH = 16, NW = 4, NO = 4;
  localparam int CNT [3] = '{NP, NH, NW};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [NP-1:0] pti_pend;
  logic [NH-1:0] hwi_pend;
  logic [NW-1:0] wti_pend;
  logic [NO-1:0] irq_out;

  always #10 clk = ~clk;  // 50 MHz

  irq_route_hub #(.N_PTI(NP), .N_HWI(NH), .N_WTI(NW), .N_OUT(NO)) u_irq_route_hub (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pti_pend(pti_pend),
    .hwi_pend(hwi_pend), .wti_pend(wti_pend), .irq_out(irq_out)
  );

  int n_vec = 0, n_bad = 0, cyc = 0;
  logic [31:0] m_msk [3][NO];

  function automatic logic [31:0] lim(int s);
    return (CNT[s] == 32) ? 32'hFFFF_FFFF : ((32'd1 << CNT[s]) - 32'd1);
  endfunction

  function automatic logic [31:0] pend_of(int s);
    case (s)
      0:       return 32'(pti_pend);
      1:       return 32'(hwi_pend);
      default: return 32'(wti_pend);
    endcase
  endfunction

  function automatic logic [31:0] low_idx(logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return 32'(i);
    return 32'd0;
  endfunction

  function automatic logic [31:0] exp_read(logic [11:0] a);
    int f = int'(a[11:7]);
    int k = int'(a[6:2]);
    logic [31:0] r = 32'd0;
    if (f == 16) return {2'b0, 6'(NO), 2'b0, 6'(NW), 2'b0, 6'(NH), 2'b0, 6'(NP)};
    if (k >= NO) return 32'd0;
    for (int s = 0; s < 3; s++) begin
      logic [31:0] act = pend_of(s) & m_msk[s][k];
      if (f == 4 + 4*s) r = m_msk[s][k];
      if (f == 6 + 4*s) r = act;
      if (f == 15 && act != 0) r = r | (32'd1 << s) | (low_idx(act) << (8 + 8*s));
    end
    return r;
  endfunction

  function automatic logic [NO-1:0] exp_irq();
    logic [NO-1:0] v = '0;
    for (int k = 0; k < NO; k++)
      for (int s = 0; s < 3; s++) if ((pend_of(s) & m_msk[s][k]) != 0) v[k] = 1'b1;
    return v;
  endfunction

  function automatic string tag_of(logic [11:0] a);
    int f = int'(a[11:7]);
    if (int'(a[6:2]) >= NO && f != 16) return "R11";
    case (f)
      4, 8, 12:  return "R2";
      6, 10, 14: return "R5";
      15:        return "R6";
      16:        return "R8";
      default:   return "R11";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%03h got=%08h exp=%08h", tag, reg_addr, got, exp);
    end
  endtask

  task automatic model_write(logic [11:0] a, logic [31:0] d);
    int f = int'(a[11:7]);
    int k = int'(a[6:2]);
    if (k >= NO) return;  // R1: out-of-range index ignored
    for (int s = 0; s < 3; s++) begin
      if (f == 4 + 4*s) m_msk[s][k] = d & lim(s);
      if (f == 5 + 4*s) m_msk[s][k] = m_msk[s][k] | (d & lim(s));
      if (f == 6 + 4*s) m_msk[s][k] = m_msk[s][k] & ~d;
    end
  endtask

  task automatic do_wr(int f, int k, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = {5'(f), 5'(k), 2'b00}; reg_wdata = d;
    @(posedge clk);
    model_write(reg_addr, d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic do_rd(int f, int k, string tag);
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = {5'(f), 5'(k), 2'b00};
    #2;
    check(tag, reg_rdata, exp_read(reg_addr));
    check("R9", 32'(irq_out), 32'(exp_irq()));
  endtask

  task automatic set_pend(logic [31:0] p, logic [31:0] h, logic [31:0] w);
    pti_pend = p[NP-1:0]; hwi_pend = h[NH-1:0]; wti_pend = w[NW-1:0];
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog R9 got=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  localparam int FN_LIST [16] = '{4, 5, 6, 8, 9, 10, 12, 13, 14, 5, 6, 13, 15, 16, 0, 7};

  initial begin
    void'($urandom(32'd4242));
    for (int s = 0; s < 3; s++) for (int k = 0; k < NO; k++) m_msk[s][k] = 32'd0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    set_pend('1, '1, '1);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R10: masks clear after reset, outputs low despite all pending
    for (int k = 0; k < NO; k++) begin
      do_rd(4, k, "R10"); do_rd(8, k, "R10"); do_rd(12, k, "R10");
    end
    check("R10", 32'(irq_out), 32'd0);

    // R8 config, R11 unsupported reads
    do_rd(16, 0, "R8");
    do_rd(5, 0, "R11"); do_rd(7, 1, "R11"); do_rd(17, 0, "R11"); do_rd(0, 2, "R11");

    // R2: bits above source count drop
    do_wr(4, 0, 32'hFFFF_FFFF); do_rd(4, 0, "R2");
    do_wr(12, 3, 32'h0000_00F6); do_rd(12, 3, "R2");
    // R1: index past last output changes nothing
    do_wr(8, 4, 32'hFFFF_FFFF); do_wr(9, 5, 32'hFFFF_FFFF);
    for (int k = 0; k < NO; k++) do_rd(8, k, "R1");
    do_rd(4, 4, "R11"); do_rd(15, 7, "R11");
    // R3 / R4 accumulation
    do_wr(9, 1, 32'h0000_0101); do_wr(9, 1, 32'h0000_8010); do_rd(8, 1, "R3");
    do_wr(10, 1, 32'h0000_0110); do_rd(8, 1, "R4");
    // R6/R7: all three types active with chosen lowest indices
    do_wr(12, 2, 32'h0000_000C); do_wr(4, 2, 32'h0000_00A0);
    do_wr(8, 2, 32'h0000_4400);
    set_pend(32'h0000_00E0, 32'h0000_FC00, 32'h0000_000F);
    do_rd(15, 2, "R6"); do_rd(6, 2, "R5"); do_rd(10, 2, "R5"); do_rd(14, 2, "R5");
    // R7: clear everything on output 2, prio reads 0
    do_wr(6, 2, 32'hFFFF_FFFF); do_wr(10, 2, 32'hFFFF_FFFF); do_wr(14, 2, 32'hFFFF_FFFF);
    do_rd(15, 2, "R7");
    do_rd(15, 3, "R7");

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      int f = FN_LIST[$urandom % 16];
      int k = int'($urandom % 6);
      logic [31:0] d = $urandom & $urandom;
      set_pend($urandom & $urandom & $urandom, $urandom & $urandom & $urandom,
               $urandom & $urandom);
      if ($urandom % 2 == 0) begin
        do_wr(f, k, d);
      end else begin
        logic [11:0] a = {5'(f), 5'(k), 2'b00};
        do_rd(f, k, tag_of(a));
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule